// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Controller

This block is the interrupt slice of a 16550-style serial port. It gathers the interrupt enable bits, the receiver error and data-ready status, the receive FIFO fill level against its trigger level, a character-timeout flag, the transmit holding register state and the modem-line change flags. From these it picks the single most urgent cause and encodes it in an identification byte. It also drives one level interrupt line toward the host.

The host reaches the block over a small synchronous register bus with a 3-bit address. Read side effects take place in the clock cycle of the read strobe. Reading the identification byte acknowledges a pending transmit-empty cause. Reading line status clears the sticky break and overrun flags. Writing the enable register can re-arm the transmit-empty cause. The serial shifter, the baud generator and the FIFO storage sit outside this block and appear only as status inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Only the highest-priority active cause is reported. The order, highest first, is: line status, character timeout, received data, transmit holding empty, modem status.
- R2: The low nibble of the identification byte is 0x1 with nothing pending, 0x6 for line status, 0xC for character timeout, 0x4 for received data, 0x2 for transmit empty and 0x0 for modem status.
- R3: The line status cause is active when enable bit 2 is set and any of break, framing error, parity error or overrun is set.
- R4: The received-data cause needs enable bit 0 and rx_ready. While fifo_en is high it also needs rx_count to be at least rx_trigger; while fifo_en is low the count is not considered.
- R5: The character-timeout cause is active only when rx_timeout is high and enable bit 0 is set; there is no separate enable for it.
- R6: The transmit-empty pending flag is set on a rising edge of tx_hold_empty and cleared while tx_hold_empty is low. It is also cleared by a read of the identification byte (address 2) that returns code 0x2. The cause is active when the flag is set and enable bit 1 is set.
- R7: A write to address 1 stores only bits 3:0 as the enable register; read-back bits 7:4 are 0. When bit 1 changes, the pending flag becomes 1 if the new bit 1 is 1 and tx_hold_empty is high, and 0 otherwise.
- R8: A read of address 5 returns line status: bit0 rx_ready, bit1 overrun, bit2 parity error, bit3 framing error, bit4 break, bit5 tx_hold_empty, bit6 tx_shift_empty, bit7 0. Break and overrun are sticky, set by their event pulses and cleared by that read. A pulse in the same cycle as the read wins.
- R9: Bits 7:6 of the identification byte read 11 while fifo_en is high and 00 otherwise; bits 5:4 read 0.
- R10: irq is a registered level, high exactly when the identification code is not 0x1. Both update one clock after their inputs. After reset, irq is 0, the identification byte is 0x01 and the enable register is 0.
- R11: bus_rdata is combinational and nonzero only while bus_rd is high. Addresses 1, 2 and 5 are readable; all others read 0. Writes to any address other than 1 are ignored. A cycle with both strobes counts as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, side effects in this cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| fifo_en | input | 1 | FIFO mode active |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| rx_ready | input | 1 | Received data available |
| rx_timeout | input | 1 | Character timeout pending |
| rx_frame_err | input | 1 | Framing error of head character |
| rx_parity_err | input | 1 | Parity error of head character |
| rx_break_evt | input | 1 | Break detected (pulse) |
| rx_overrun_evt | input | 1 | Overrun occurred (pulse) |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_shift_empty | input | 1 | Transmitter fully idle |
| modem_delta | input | 4 | Modem line change flags |
| irq | output | 1 | Interrupt request level |

## Verification
The embedded properties check several rules on every cycle:
- an enabled line error wins the next identification value;
- a disabled timeout never yields code 0xC;
- any active cause raises irq one clock later;
- the FIFO flag bits track fifo_en;
- the transmit-empty flag is only ever set after tx_hold_empty was high;
- a line status read clears break unless a new break arrives;
- enable writes land in the register.

Only the bench scenarios can show the full priority descent as causes drop one by one, and the one-cycle lag before an acknowledged transmit-empty code disappears. The same holds for re-arming through an enable toggle, the FIFO trigger threshold and the same-cycle race between a line status read and an overrun pulse.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IRQ_MODEM    = 4'h0,
        IRQ_NONE     = 4'h1,
        IRQ_TX_EMPTY = 4'h2,
        IRQ_RX_DATA  = 4'h4,
        IRQ_LINE     = 4'h6,
        IRQ_TIMEOUT  = 4'hC
    } irq_code_e;

    // cause index, highest priority at 0
    localparam int SRC_LINE    = 0;
    localparam int SRC_TIMEOUT = 1;
    localparam int SRC_RXDATA  = 2;
    localparam int SRC_TX      = 3;
    localparam int SRC_MODEM   = 4;
    localparam int NUM_SRC     = 5;

    localparam logic [2:0] ADDR_ENABLE = 3'd1;
    localparam logic [2:0] ADDR_IDENT  = 3'd2;
    localparam logic [2:0] ADDR_LSTAT  = 3'd5;

    localparam int ENABLE_W = 4;

    function automatic logic [3:0] src_code(input int idx);
        case (idx)
            SRC_LINE:    src_code = IRQ_LINE;
            SRC_TIMEOUT: src_code = IRQ_TIMEOUT;
            SRC_RXDATA:  src_code = IRQ_RX_DATA;
            SRC_TX:      src_code = IRQ_TX_EMPTY;
            default:     src_code = IRQ_MODEM;
        endcase
    endfunction

    typedef struct packed {
        logic [ENABLE_W-1:0] ier;
        logic                brk;
        logic                ovr;
        logic                tx_pend;
        logic                tx_prev;
    } status_t;

    typedef struct packed {
        logic [7:0] ident;
        logic       irq;
    } out_t;

endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ier_wr,
    input  logic [ENABLE_W-1:0] ier_wdata,
    input  logic                ident_rd,
    input  logic                ident_is_tx,
    input  logic                lstat_rd,
    input  logic                break_evt,
    input  logic                overrun_evt,
    input  logic                tx_hold_empty,
    output logic [ENABLE_W-1:0] ier,
    output logic                brk,
    output logic                ovr,
    output logic                tx_pend
);

    status_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.tx_prev = tx_hold_empty;

        if (lstat_rd) begin
            st_d.brk = 1'b0;
            st_d.ovr = 1'b0;
        end
        if (break_evt)   st_d.brk = 1'b1;
        if (overrun_evt) st_d.ovr = 1'b1;

        if (tx_hold_empty && !st_q.tx_prev) st_d.tx_pend = 1'b1;
        if (!tx_hold_empty)                 st_d.tx_pend = 1'b0;
        if (ident_rd && ident_is_tx)        st_d.tx_pend = 1'b0;

        if (ier_wr) begin
            st_d.ier = ier_wdata;
            if (ier_wdata[1] != st_q.ier[1])
                st_d.tx_pend = ier_wdata[1] && tx_hold_empty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ier: '0, brk: 1'b0, ovr: 1'b0, tx_pend: 1'b0, tx_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ier     = st_q.ier;
    assign brk     = st_q.brk;
    assign ovr     = st_q.ovr;
    assign tx_pend = st_q.tx_pend;

    assert_tx_pend_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pend |-> $past(tx_hold_empty));

    assert_lstat_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lstat_rd && !break_evt) |=> !brk);

    assert_break_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        break_evt |=> brk);

    assert_enable_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> (ier == $past(ier_wdata)));

endmodule

// File: rtl/uart_irq_src_eval.sv
module uart_irq_src_eval
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [ENABLE_W-1:0] ier,
    input  logic                line_err,
    input  logic                rx_timeout,
    input  logic                rx_ready,
    input  logic                fifo_en,
    input  logic [CNT_W-1:0]    rx_count,
    input  logic [CNT_W-1:0]    rx_trigger,
    input  logic                tx_pend,
    input  logic                modem_any,
    output logic [3:0]          code,
    output logic                any_active
);

    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] grant;

    always_comb begin
        active              = '0;
        active[SRC_LINE]    = ier[2] && line_err;
        active[SRC_TIMEOUT] = ier[0] && rx_timeout;
        active[SRC_RXDATA]  = ier[0] && rx_ready && (!fifo_en || (rx_count >= rx_trigger));
        active[SRC_TX]      = ier[1] && tx_pend;
        active[SRC_MODEM]   = ier[3] && modem_any;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_grant
            if (gi == 0) begin : g_top
                assign grant[gi] = active[gi];
            end else begin : g_rest
                assign grant[gi] = active[gi] && !(|active[gi-1:0]);
            end
        end
    endgenerate

    always_comb begin
        code = IRQ_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) code = src_code(i);
        end
    end

    assign any_active = |active;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_rd,
    input  logic             bus_wr,
    output logic [7:0]       bus_rdata,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trigger,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             rx_frame_err,
    input  logic             rx_parity_err,
    input  logic             rx_break_evt,
    input  logic             rx_overrun_evt,
    input  logic             tx_hold_empty,
    input  logic             tx_shift_empty,
    input  logic [3:0]       modem_delta,
    output logic             irq
);

    out_t out_d, out_q;

    logic                rd_eff;
    logic                ier_wr, ident_rd, lstat_rd;
    logic [ENABLE_W-1:0] ier;
    logic                brk, ovr, tx_pend;
    logic [3:0]          code;
    logic                any_active;
    logic [7:0]          lstat;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[7:ENABLE_W];

    assign rd_eff   = bus_rd && !bus_wr;
    assign ier_wr   = bus_wr && (bus_addr == ADDR_ENABLE);
    assign ident_rd = rd_eff && (bus_addr == ADDR_IDENT);
    assign lstat_rd = rd_eff && (bus_addr == ADDR_LSTAT);

    uart_irq_status status_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ier_wr        (ier_wr),
        .ier_wdata     (bus_wdata[ENABLE_W-1:0]),
        .ident_rd      (ident_rd),
        .ident_is_tx   (out_q.ident[3:0] == IRQ_TX_EMPTY),
        .lstat_rd      (lstat_rd),
        .break_evt     (rx_break_evt),
        .overrun_evt   (rx_overrun_evt),
        .tx_hold_empty (tx_hold_empty),
        .ier           (ier),
        .brk           (brk),
        .ovr           (ovr),
        .tx_pend       (tx_pend)
    );

    uart_irq_src_eval #(.CNT_W(CNT_W)) eval_i (
        .ier        (ier),
        .line_err   (brk || ovr || rx_frame_err || rx_parity_err),
        .rx_timeout (rx_timeout),
        .rx_ready   (rx_ready),
        .fifo_en    (fifo_en),
        .rx_count   (rx_count),
        .rx_trigger (rx_trigger),
        .tx_pend    (tx_pend),
        .modem_any  (|modem_delta),
        .code       (code),
        .any_active (any_active)
    );

    always_comb begin
        out_d       = out_q;
        out_d.ident = {{2{fifo_en}}, 2'b00, code};
        out_d.irq   = (code != IRQ_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{ident: {4'h0, IRQ_NONE}, irq: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign lstat = {1'b0, tx_shift_empty, tx_hold_empty, brk,
                    rx_frame_err, rx_parity_err, ovr, rx_ready};

    always_comb begin
        bus_rdata = 8'h00;
        if (rd_eff) begin
            case (bus_addr)
                ADDR_ENABLE: bus_rdata = {{(8-ENABLE_W){1'b0}}, ier};
                ADDR_IDENT:  bus_rdata = out_q.ident;
                ADDR_LSTAT:  bus_rdata = lstat;
                default:     bus_rdata = 8'h00;
            endcase
        end
    end

    assign irq = out_q.irq;

    assert_line_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[2] && rx_frame_err) |=> (out_q.ident[3:0] == IRQ_LINE));

    assert_timeout_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout && !ier[0]) |=> (out_q.ident[3:0] != IRQ_TIMEOUT));

    assert_below_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && (rx_count < rx_trigger)) |=> (out_q.ident[3:0] != IRQ_RX_DATA));

    assert_fifo_flag_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_q.ident[7:4] == {{2{$past(fifo_en)}}, 2'b00}));

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_active |=> irq);

endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk, rst_n;
    logic [2:0]    bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic          bus_rd, bus_wr;
    logic          fifo_en;
    logic [CW-1:0] rx_count, rx_trigger;
    logic          rx_ready, rx_timeout, rx_frame_err, rx_parity_err;
    logic          rx_break_evt, rx_overrun_evt;
    logic          tx_hold_empty, tx_shift_empty;
    logic [3:0]    modem_delta;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    uart_irq_ctrl #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .fifo_en(fifo_en), .rx_count(rx_count), .rx_trigger(rx_trigger),
        .rx_ready(rx_ready), .rx_timeout(rx_timeout), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .rx_break_evt(rx_break_evt),
        .rx_overrun_evt(rx_overrun_evt), .tx_hold_empty(tx_hold_empty),
        .tx_shift_empty(tx_shift_empty), .modem_delta(modem_delta), .irq(irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference model
    logic [3:0] m_ier;
    logic       m_bi, m_oe, m_pend, m_prev, m_irq;
    logic [7:0] m_iir;

    always @(posedge clk or negedge rst_n) begin
        logic [3:0] c;
        logic       rd_ok;
        if (!rst_n) begin
            m_ier = 4'h0; m_bi = 0; m_oe = 0; m_pend = 0; m_prev = 1;
            m_iir = 8'h01; m_irq = 0;
        end else begin
            if (m_ier[2] && (m_bi || m_oe || rx_frame_err || rx_parity_err)) c = 4'h6;
            else if (m_ier[0] && rx_timeout) c = 4'hC;
            else if (m_ier[0] && rx_ready && (!fifo_en || rx_count >= rx_trigger)) c = 4'h4;
            else if (m_ier[1] && m_pend) c = 4'h2;
            else if (m_ier[3] && (modem_delta != 0)) c = 4'h0;
            else c = 4'h1;
            rd_ok = bus_rd && !bus_wr;
            if (rd_ok && bus_addr == 3'd5) begin m_bi = 0; m_oe = 0; end
            if (rx_break_evt) m_bi = 1;
            if (rx_overrun_evt) m_oe = 1;
            if (tx_hold_empty && !m_prev) m_pend = 1;
            if (!tx_hold_empty) m_pend = 0;
            if (rd_ok && bus_addr == 3'd2 && m_iir[3:0] == 4'h2) m_pend = 0;
            if (bus_wr && bus_addr == 3'd1) begin
                if (bus_wdata[1] != m_ier[1]) m_pend = bus_wdata[1] && tx_hold_empty;
                m_ier = bus_wdata[3:0];
            end
            m_prev = tx_hold_empty;
            m_iir  = {fifo_en ? 2'b11 : 2'b00, 2'b00, c};
            m_irq  = (c != 4'h1);
        end
    end

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        if (!bus_rd || bus_wr) return 8'h00;
        case (a)
            3'd1: return {4'h0, m_ier};
            3'd2: return m_iir;
            3'd5: return {1'b0, tx_shift_empty, tx_hold_empty, m_bi,
                          rx_frame_err, rx_parity_err, m_oe, rx_ready};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of the interrupt line against the model (R10)
    always @(negedge clk) begin
        if (rst_n && !done) chk8("R10 irq vs model", {7'h0, irq}, {7'h0, m_irq});
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) step();
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
        step();
    endtask

    task automatic rd_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk8(tag, bus_rdata, exp);
        chk8({tag, " model"}, bus_rdata, model_rd(a));
        step();
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_rd = 0; bus_wr = 0;
        fifo_en = 0; rx_count = 0; rx_trigger = 0; rx_ready = 0; rx_timeout = 0;
        rx_frame_err = 0; rx_parity_err = 0; rx_break_evt = 0; rx_overrun_evt = 0;
        tx_hold_empty = 1; tx_shift_empty = 1; modem_delta = 0;
        wait_n(3);
        rst_n = 1;
        wait_n(2);

        // reset state
        chk8("R10 reset irq", {7'h0, irq}, 8'h00);
        rd_reg(3'd2, 8'h01, "R10 reset ident");
        rd_reg(3'd1, 8'h00, "R10 reset enable");
        rd_reg(3'd5, 8'h60, "R8 reset line status");

        // enable write, upper bits dropped, transmit-empty armed
        wr_reg(3'd1, 8'hFF);
        chk8("R10 irq high", {7'h0, irq}, 8'h01);
        rd_reg(3'd1, 8'h0F, "R7 enable low nibble only");
        rd_reg(3'd2, 8'h02, "R6 tx empty code");
        step();
        rd_reg(3'd2, 8'h01, "R6 ident read acknowledges");
        chk8("R10 irq low after ack", {7'h0, irq}, 8'h00);

        // re-arm by toggling enable bit 1
        wr_reg(3'd1, 8'h0D);
        wr_reg(3'd1, 8'h0F);
        rd_reg(3'd2, 8'h02, "R7 re-arm on enable toggle");
        step();

        // rising edge of hold empty sets, low clears
        tx_hold_empty = 0; wait_n(2);
        tx_hold_empty = 1; wait_n(2);
        chk8("R6 rise sets pending", {7'h0, irq}, 8'h01);
        tx_hold_empty = 0; wait_n(2);
        rd_reg(3'd2, 8'h01, "R6 low hold clears pending");
        tx_hold_empty = 1; wait_n(2);

        // priority descent
        modem_delta = 4'h1; rx_ready = 1; rx_timeout = 1; rx_frame_err = 1;
        wait_n(2);
        rd_reg(3'd2, 8'h06, "R1 line status highest");
        rx_frame_err = 0; wait_n(2);
        rd_reg(3'd2, 8'h0C, "R1 timeout second");
        rx_timeout = 0; wait_n(2);
        rd_reg(3'd2, 8'h04, "R4 rx data without fifo");
        rx_ready = 0; wait_n(2);
        rd_reg(3'd2, 8'h02, "R1 tx empty fourth");
        step();
        rd_reg(3'd2, 8'h00, "R2 modem code");
        chk8("R2 modem raises irq", {7'h0, irq}, 8'h01);
        modem_delta = 0; wait_n(2);
        rd_reg(3'd2, 8'h01, "R2 none pending");

        // timeout gated by rx data enable
        wr_reg(3'd1, 8'h0E);
        rx_timeout = 1; wait_n(2);
        rd_reg(3'd2, 8'h01, "R5 timeout masked");
        chk8("R5 irq stays low", {7'h0, irq}, 8'h00);
        rx_timeout = 0;
        wr_reg(3'd1, 8'h0F);

        // fifo trigger level and flag bits
        wr_reg(3'd1, 8'h01);
        fifo_en = 1; rx_ready = 1; rx_count = 3; rx_trigger = 4; wait_n(2);
        rd_reg(3'd2, 8'hC1, "R9 fifo flags, R4 below trigger");
        rx_count = 4; wait_n(2);
        rd_reg(3'd2, 8'hC4, "R4 at trigger");
        rx_count = 5; wait_n(2);
        rd_reg(3'd2, 8'hC4, "R4 above trigger");
        fifo_en = 0; rx_count = 0; wait_n(2);
        rd_reg(3'd2, 8'h04, "R9 flags clear, R4 count ignored");
        rx_ready = 0; wait_n(2);

        // line status sticky bits
        wr_reg(3'd1, 8'h04);
        rx_break_evt = 1; step(); rx_break_evt = 0; wait_n(2);
        rd_reg(3'd2, 8'h06, "R3 break raises line status");
        rd_reg(3'd5, 8'h70, "R8 break bit reads");
        wait_n(2);
        rd_reg(3'd5, 8'h60, "R8 break cleared by read");
        rd_reg(3'd2, 8'h01, "R3 line status gone");
        rx_overrun_evt = 1; step(); rx_overrun_evt = 0; wait_n(2);
        rx_overrun_evt = 1;
        rd_reg(3'd5, 8'h62, "R8 overrun bit reads");
        rx_overrun_evt = 0;
        rd_reg(3'd5, 8'h62, "R8 pulse beats read clear");
        rd_reg(3'd5, 8'h60, "R8 overrun cleared");
        rx_parity_err = 1; rx_ready = 1; wait_n(2);
        rd_reg(3'd5, 8'h65, "R8 parity and ready bits");
        rd_reg(3'd2, 8'h06, "R3 parity raises line status");
        rx_parity_err = 0; rx_ready = 0; wait_n(2);

        // bus decode
        wr_reg(3'd3, 8'h00);
        rd_reg(3'd1, 8'h04, "R11 write elsewhere ignored");
        rd_reg(3'd7, 8'h00, "R11 unmapped reads zero");
        bus_addr = 3'd1; #1;
        chk8("R11 idle rdata zero", bus_rdata, 8'h00);
        step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule